// File: doc/BRIEF.md
# Reservation Station Pool

This block holds instructions that have left the in-order issue stage but cannot yet run. Seven stations are split into three functional-unit classes: two for loads, three for add/subtract and two for multiply/divide. Each station is named by a 3-bit tag. Every source operand is stored in one of two forms: a ready value, or the tag of the station that will produce it. A single result bus broadcasts a tag and a value. Every station waiting on that tag takes the value.

Issue takes one instruction per cycle into the lowest free station of its class, or refuses it with a stall. On every cycle, each class presents one ready station to its functional unit, the lowest-numbered one. This happens without regard to program order. A station stays occupied after dispatch until its own result is broadcast. Load stations also combine a base operand and an offset into an effective address.

Top module: `rs_pool`

## Requirements
- R1: After reset all seven stations are free (`free_mask` = 7'h7f, where bit i stands for tag i+1), no dispatch output is valid and `iss_stall` is low.
- R2: Class codes are 0 = load, 1 = add/subtract, 2 = multiply/divide. The tags are 1–2 for load, 3–5 for add and 6–7 for multiply. An accepted issue takes the lowest free tag of its class and reports it on `iss_tag` in the same cycle. That station's `free_mask` bit clears from the next cycle.
- R3: `iss_stall` is high, and no station is written, when `iss_valid` is high and either no station of the requested class is free or the class code is 3.
- R4: An issued operand whose producer tag is 0 is treated as valid. A station with both tags at 0 is presented for dispatch in the cycle after issue, with its op and both values.
- R5: A valid broadcast with a nonzero tag loads its value into every waiting operand that holds that tag and clears the tag. A station made ready this way is presented for dispatch in the following cycle with the captured value.
- R6: If an operand's tag matches the broadcast in the same cycle that the operand is issued, the operand is captured at issue and does not wait.
- R7: Within a class, the lowest-numbered ready station is dispatched, even while an older station of lower number is still waiting. Each issued instruction is dispatched exactly once.
- R8: A valid broadcast of a station's own tag frees that station from the next cycle. A broadcast with `cdb_valid` low, or with tag 0, changes no station.
- R9: A load dispatches when its base operand (Vj) is valid. Its issued Vk tag is ignored. `ld_addr` equals the base plus the issued offset `iss_imm`, modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_class | input | 2 | Class code of the issued instruction |
| iss_op | input | OP_W | Operation code |
| iss_vj | input | DATA_W | First operand value (load base) |
| iss_qj | input | 3 | First operand producer tag, 0 = valid |
| iss_vk | input | DATA_W | Second operand value |
| iss_qk | input | 3 | Second operand producer tag, 0 = valid |
| iss_imm | input | DATA_W | Load offset |
| iss_stall | output | 1 | Issue refused |
| iss_tag | output | 3 | Tag given to the accepted instruction |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 3 | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| free_mask | output | 7 | Bit i high when station of tag i+1 is free |
| ld_valid | output | 1 | Load dispatch valid |
| ld_tag | output | 3 | Tag of dispatched load |
| ld_addr | output | DATA_W | Effective address of dispatched load |
| alu_valid | output | 1 | Add/subtract dispatch valid |
| alu_tag | output | 3 | Tag of dispatched add/subtract |
| alu_op | output | OP_W | Its operation code |
| alu_vj | output | DATA_W | Its first operand |
| alu_vk | output | DATA_W | Its second operand |
| mul_valid | output | 1 | Multiply/divide dispatch valid |
| mul_tag | output | 3 | Tag of dispatched multiply/divide |
| mul_op | output | OP_W | Its operation code |
| mul_vj | output | DATA_W | Its first operand |
| mul_vk | output | DATA_W | Its second operand |

## Verification
The bench fills every class until it stalls and then releases all of them with one broadcast. This exposes a design that wakes only one station, or that writes a station while stalled. It issues an operand in the same cycle that its producer broadcasts. A design without the bypass would leave that station waiting forever. It also makes a younger station ready ahead of an older waiting one, which catches any in-order or highest-first picker, and it checks that each station dispatches only once. Broadcasts with the valid low or with tag 0 are shown to wake nothing. Address sweeps that wrap past 2^16 catch a truncated or mis-summed effective address.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int TAG_W   = 3;
    localparam int NUM_RS  = 7;
    localparam int NUM_CLS = 3;

    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        CLS_LD  = 2'd0,
        CLS_ALU = 2'd1,
        CLS_MUL = 2'd2
    } rs_class_e;

    // first station index of a class
    function automatic int cls_base(int c);
        case (c)
            0:       return 0;
            1:       return 2;
            default: return 5;
        endcase
    endfunction

    // number of stations in a class
    function automatic int cls_count(int c);
        return (c == 1) ? 3 : 2;
    endfunction

    // class number of a station index
    function automatic int cls_idx(int i);
        if (i < 2) return 0;
        if (i < 5) return 1;
        return 2;
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick
    import rs_pkg::*;
#(
    parameter int N        = 2,
    parameter int BASE_TAG = 1
) (
    input  logic [N-1:0] req,
    output logic         found,
    output tag_t         tag
);

    // lowest set request wins
    always_comb begin
        found = 1'b0;
        tag   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                tag   = tag_t'(BASE_TAG + i);
            end
        end
    end

endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int   DATA_W = 16,
    parameter int   OP_W   = 4,
    parameter tag_t MY_TAG = 3'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_vj,
    input  tag_t              in_qj,
    input  logic [DATA_W-1:0] in_vk,
    input  tag_t              in_qk,
    input  logic [DATA_W-1:0] in_imm,
    input  logic              grant,
    input  logic              cdb_valid,
    input  tag_t              cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              busy_o,
    output logic              ready_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o,
    output logic [DATA_W-1:0] addr_o
);

    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        tag_t              qj;
        tag_t              qk;
        logic [DATA_W-1:0] addr;
    } entry_t;

    entry_t st;

    logic in_hit_j, in_hit_k, hit_j, hit_k, own_done;

    always_comb begin
        in_hit_j = cdb_valid && (in_qj != '0) && (cdb_tag == in_qj);
        in_hit_k = cdb_valid && (in_qk != '0) && (cdb_tag == in_qk);
        hit_j    = cdb_valid && (st.qj != '0) && (cdb_tag == st.qj);
        hit_k    = cdb_valid && (st.qk != '0) && (cdb_tag == st.qk);
        own_done = cdb_valid && (cdb_tag == MY_TAG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (alloc) begin
            st.busy <= 1'b1;
            st.sent <= 1'b0;
            st.op   <= in_op;
            st.addr <= in_imm;
            st.vj   <= in_hit_j ? cdb_value : in_vj;
            st.qj   <= in_hit_j ? '0 : in_qj;
            st.vk   <= in_hit_k ? cdb_value : in_vk;
            st.qk   <= in_hit_k ? '0 : in_qk;
        end else if (st.busy) begin
            if (own_done) begin
                st.busy <= 1'b0;
                st.sent <= 1'b0;
            end else begin
                if (grant) st.sent <= 1'b1;
                if (hit_j) begin
                    st.vj <= cdb_value;
                    st.qj <= '0;
                end
                if (hit_k) begin
                    st.vk <= cdb_value;
                    st.qk <= '0;
                end
            end
        end
    end

    assign busy_o  = st.busy;
    assign ready_o = st.busy && !st.sent && (st.qj == '0) && (st.qk == '0);
    assign op_o    = st.op;
    assign vj_o    = st.vj;
    assign vk_o    = st.vk;
    assign addr_o  = st.addr;

    // R8: own broadcast releases the station
    a_r8_release_on_own_tag: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !alloc && own_done) |=> !busy_o);

    // R7: a granted station is never offered again
    a_r7_dispatch_once: assert property (@(posedge clk) disable iff (rst)
        (grant && !own_done) |=> !ready_o);

    // R5: waiting operand takes the broadcast value
    a_r5_capture_j: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !alloc && !own_done && hit_j) |=> (vj_o == $past(cdb_value)));

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [1:0]        iss_class,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [2:0]        iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [2:0]        iss_qk,
    input  logic [DATA_W-1:0] iss_imm,
    output logic              iss_stall,
    output logic [2:0]        iss_tag,
    input  logic              cdb_valid,
    input  logic [2:0]        cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic [6:0]        free_mask,
    output logic              ld_valid,
    output logic [2:0]        ld_tag,
    output logic [DATA_W-1:0] ld_addr,
    output logic              alu_valid,
    output logic [2:0]        alu_tag,
    output logic [OP_W-1:0]   alu_op,
    output logic [DATA_W-1:0] alu_vj,
    output logic [DATA_W-1:0] alu_vk,
    output logic              mul_valid,
    output logic [2:0]        mul_tag,
    output logic [OP_W-1:0]   mul_op,
    output logic [DATA_W-1:0] mul_vj,
    output logic [DATA_W-1:0] mul_vk
);

    logic [NUM_RS-1:0] busy, ready, alloc, grant;
    logic [OP_W-1:0]   st_op   [NUM_RS];
    logic [DATA_W-1:0] st_vj   [NUM_RS];
    logic [DATA_W-1:0] st_vk   [NUM_RS];
    logic [DATA_W-1:0] st_addr [NUM_RS];

    logic [NUM_CLS-1:0] free_found, disp_found;
    tag_t               free_tag  [NUM_CLS];
    tag_t               disp_tag  [NUM_CLS];

    logic sel_found;
    tag_t sel_tag;

    // per-class allocation and dispatch pickers
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam int B = cls_base(c);
        localparam int N = cls_count(c);
        logic [N-1:0] idle_v;
        assign idle_v = ~busy[B +: N];

        rs_pick #(.N(N), .BASE_TAG(B + 1)) u_alloc_pick (
            .req   (idle_v),
            .found (free_found[c]),
            .tag   (free_tag[c])
        );

        rs_pick #(.N(N), .BASE_TAG(B + 1)) u_disp_pick (
            .req   (ready[B +: N]),
            .found (disp_found[c]),
            .tag   (disp_tag[c])
        );
    end

    always_comb begin
        sel_found = 1'b0;
        sel_tag   = '0;
        case (iss_class)
            CLS_LD, CLS_ALU, CLS_MUL: begin
                sel_found = free_found[iss_class];
                sel_tag   = free_tag[iss_class];
            end
            default: ;
        endcase
    end

    assign iss_stall = iss_valid && !sel_found;
    assign iss_tag   = sel_found ? sel_tag : '0;
    assign free_mask = ~busy;

    always_comb begin
        for (int i = 0; i < NUM_RS; i++) begin
            alloc[i] = iss_valid && sel_found && (sel_tag == tag_t'(i + 1));
            grant[i] = disp_found[cls_idx(i)] && (disp_tag[cls_idx(i)] == tag_t'(i + 1));
        end
    end

    for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
        localparam bit IS_LD = (cls_idx(i) == 0);
        logic [DATA_W-1:0] vk_in;
        tag_t              qk_in;
        assign vk_in = IS_LD ? '0 : iss_vk;
        assign qk_in = IS_LD ? '0 : iss_qk;

        rs_entry #(.DATA_W(DATA_W), .OP_W(OP_W), .MY_TAG(tag_t'(i + 1))) u_rs (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc[i]),
            .in_op     (iss_op),
            .in_vj     (iss_vj),
            .in_qj     (iss_qj),
            .in_vk     (vk_in),
            .in_qk     (qk_in),
            .in_imm    (iss_imm),
            .grant     (grant[i]),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .busy_o    (busy[i]),
            .ready_o   (ready[i]),
            .op_o      (st_op[i]),
            .vj_o      (st_vj[i]),
            .vk_o      (st_vk[i]),
            .addr_o    (st_addr[i])
        );
    end

    // dispatch output steering
    always_comb begin
        ld_addr = '0;
        alu_op  = '0;
        alu_vj  = '0;
        alu_vk  = '0;
        mul_op  = '0;
        mul_vj  = '0;
        mul_vk  = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (disp_tag[0] == tag_t'(i + 1)) ld_addr = st_vj[i] + st_addr[i];
            if (disp_tag[1] == tag_t'(i + 1)) begin
                alu_op = st_op[i];
                alu_vj = st_vj[i];
                alu_vk = st_vk[i];
            end
            if (disp_tag[2] == tag_t'(i + 1)) begin
                mul_op = st_op[i];
                mul_vj = st_vj[i];
                mul_vk = st_vk[i];
            end
        end
    end

    assign ld_valid  = disp_found[0];
    assign ld_tag    = disp_tag[0];
    assign alu_valid = disp_found[1];
    assign alu_tag   = disp_tag[1];
    assign mul_valid = disp_found[2];
    assign mul_tag   = disp_tag[2];

    // R1: state just out of reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&free_mask && !ld_valid && !alu_valid && !mul_valid));

    // R2: accepted tag lies in the requested class
    a_r2_tag_in_class: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_stall) |-> (iss_tag != 3'd0 &&
            cls_idx(int'(iss_tag) - 1) == int'(iss_class)));

    // R2: the given station reads busy next cycle
    a_r2_taken_next: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_stall) |=> !free_mask[$past(iss_tag) - 3'd1]);

    // R3: stall only when the class has no free bit
    a_r3_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        (iss_stall && iss_class == 2'd1) |-> (free_mask[4:2] == 3'b000));

endmodule

// File: tb/rs_pool_test.sv
`timescale 1ns/1ps
module rs_pool_test;

    localparam int DW = 16;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid;
    logic [1:0]    iss_class;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_vj, iss_vk, iss_imm;
    logic [2:0]    iss_qj, iss_qk;
    logic          iss_stall;
    logic [2:0]    iss_tag;
    logic          cdb_valid;
    logic [2:0]    cdb_tag;
    logic [DW-1:0] cdb_value;
    logic [6:0]    free_mask;
    logic          ld_valid, alu_valid, mul_valid;
    logic [2:0]    ld_tag, alu_tag, mul_tag;
    logic [DW-1:0] ld_addr, alu_vj, alu_vk, mul_vj, mul_vk;
    logic [OW-1:0] alu_op, mul_op;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rs_pool #(.DATA_W(DW), .OP_W(OW)) uut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_class(iss_class), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_imm(iss_imm), .iss_stall(iss_stall), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .free_mask(free_mask),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
        .alu_valid(alu_valid), .alu_tag(alu_tag), .alu_op(alu_op),
        .alu_vj(alu_vj), .alu_vk(alu_vk),
        .mul_valid(mul_valid), .mul_tag(mul_tag), .mul_op(mul_op),
        .mul_vj(mul_vj), .mul_vk(mul_vk)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(bit iv, logic [1:0] cls, logic [OW-1:0] op,
                         logic [DW-1:0] vj, logic [2:0] qj,
                         logic [DW-1:0] vk, logic [2:0] qk, logic [DW-1:0] imm,
                         bit cv, logic [2:0] ct, logic [DW-1:0] cval);
        @(negedge clk);
        iss_valid = iss_valid ^ iss_valid ^ iv;
        iss_class = cls; iss_op = op;
        iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk; iss_imm = imm;
        cdb_valid = cv; cdb_tag = ct; cdb_value = cval;
        #1;
    endtask

    task automatic t_issue(logic [1:0] cls, logic [OW-1:0] op, logic [DW-1:0] vj,
                           logic [2:0] qj, logic [DW-1:0] vk, logic [2:0] qk,
                           logic [DW-1:0] imm);
        drive(1, cls, op, vj, qj, vk, qk, imm, 0, 3'd0, '0);
    endtask

    task automatic t_bcast(logic [2:0] t, logic [DW-1:0] v);
        drive(0, 2'd0, '0, '0, 3'd0, '0, 3'd0, '0, 1, t, v);
    endtask

    task automatic t_idle();
        drive(0, 2'd0, '0, '0, 3'd0, '0, 3'd0, '0, 0, 3'd0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        iss_valid = 0;
        t_idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_idle();
        // R1
        chk("R1", "free_mask", 32'(free_mask), 32'h7f);
        chk("R1", "no dispatch", 32'({ld_valid, alu_valid, mul_valid}), 32'h0);
        chk("R1", "no stall", 32'(iss_stall), 32'h0);

        // R2 / R3: fill every class with waiting work
        for (int i = 0; i < 4; i++) begin
            t_issue(2'd1, OW'(i), '0, 3'd7, DW'(16'h100 + i), 3'd0, '0);
            if (i < 3) begin
                chk("R2", "alu tag", 32'(iss_tag), 32'(3 + i));
                chk("R2", "alu no stall", 32'(iss_stall), 0);
            end else chk("R3", "alu stall", 32'(iss_stall), 1);
        end
        for (int i = 0; i < 3; i++) begin
            t_issue(2'd0, '0, '0, 3'd7, '0, 3'd0, 16'h0010);
            if (i < 2) chk("R2", "load tag", 32'(iss_tag), 32'(1 + i));
            else chk("R3", "load stall", 32'(iss_stall), 1);
        end
        for (int i = 0; i < 3; i++) begin
            t_issue(2'd2, 4'd5, '0, 3'd3, 16'h0200, 3'd0, '0);
            if (i < 2) chk("R2", "mul tag", 32'(iss_tag), 32'(6 + i));
            else chk("R3", "mul stall", 32'(iss_stall), 1);
        end
        t_issue(2'd3, '0, '0, 3'd0, '0, 3'd0, '0);
        chk("R3", "class 3 stall", 32'(iss_stall), 1);
        t_idle();
        chk("R2", "all taken", 32'(free_mask), 32'h0);
        chk("R4", "waiting stations idle", 32'({ld_valid, alu_valid, mul_valid}), 0);

        // R5: one broadcast wakes loads and adds, frees mul 7
        t_bcast(3'd7, 16'h1234);
        t_idle();
        chk("R5", "alu tag", 32'(alu_tag), 3);
        chk("R5", "alu vj", 32'(alu_vj), 32'h1234);
        chk("R5", "alu vk", 32'(alu_vk), 32'h100);
        chk("R9", "ld tag", 32'({ld_valid, ld_tag}), 32'h9);
        chk("R9", "ld addr", 32'(ld_addr), 32'h1244);
        chk("R8", "mul 7 freed", 32'(free_mask), 32'h40);
        chk("R5", "mul waits", 32'(mul_valid), 0);
        t_idle();
        chk("R7", "alu next", 32'({alu_valid, alu_tag}), 32'hc);
        chk("R7", "alu vk", 32'(alu_vk), 32'h101);
        chk("R7", "ld next", 32'({ld_valid, ld_tag}), 32'ha);
        t_idle();
        chk("R7", "alu last", 32'({alu_valid, alu_tag}), 32'hd);
        chk("R7", "ld once", 32'(ld_valid), 0);
        t_idle();
        chk("R7", "alu once", 32'(alu_valid), 0);

        // R5 / R8: add 3 result wakes mul 6
        t_bcast(3'd3, 16'h0abc);
        t_idle();
        chk("R5", "mul tag", 32'({mul_valid, mul_tag}), 32'he);
        chk("R5", "mul op", 32'(mul_op), 5);
        chk("R5", "mul vj", 32'(mul_vj), 32'h0abc);
        chk("R5", "mul vk", 32'(mul_vk), 32'h0200);
        chk("R8", "freed 3", 32'(free_mask), 32'h44);

        // R8: invalid or zero-tag broadcasts ignored
        t_issue(2'd1, 4'd1, '0, 3'd6, 16'd5, 3'd0, '0);
        chk("R2", "reuse tag 3", 32'(iss_tag), 3);
        drive(0, 2'd0, '0, '0, 3'd0, '0, 3'd0, '0, 0, 3'd6, 16'hdead);
        drive(0, 2'd0, '0, '0, 3'd0, '0, 3'd0, '0, 1, 3'd0, 16'hbeef);
        t_idle();
        chk("R8", "no wake", 32'(alu_valid), 0);
        chk("R8", "no free", 32'(free_mask), 32'h40);
        t_bcast(3'd6, 16'h7777);
        t_idle();
        chk("R5", "woken", 32'({alu_valid, alu_tag}), 32'hb);
        chk("R5", "vj", 32'(alu_vj), 32'h7777);
        chk("R5", "op", 32'(alu_op), 1);
        chk("R8", "freed 6", 32'(free_mask), 32'h60);
        for (int t = 1; t <= 5; t++) t_bcast(3'(t), '0);
        t_idle();
        chk("R8", "all free", 32'(free_mask), 32'h7f);

        // R6: capture at issue
        drive(1, 2'd1, 4'd2, '0, 3'd6, 16'd9, 3'd0, '0, 1, 3'd6, 16'h4242);
        chk("R6", "tag", 32'(iss_tag), 3);
        t_idle();
        chk("R6", "alu ready", 32'({alu_valid, alu_tag}), 32'hb);
        chk("R6", "vj", 32'(alu_vj), 32'h4242);
        drive(1, 2'd2, 4'd3, 16'd2, 3'd0, '0, 3'd4, '0, 1, 3'd4, 16'h0055);
        chk("R6", "mul tag", 32'(iss_tag), 6);
        t_idle();
        chk("R6", "mul ready", 32'({mul_valid, mul_tag}), 32'he);
        chk("R6", "mul vk", 32'(mul_vk), 32'h0055);
        t_bcast(3'd3, '0);
        t_bcast(3'd6, '0);

        // R7: younger ready goes first; priority among ready
        t_issue(2'd1, 4'd4, '0, 3'd7, 16'd1, 3'd0, '0);
        t_issue(2'd1, 4'd7, 16'd11, 3'd0, 16'd22, 3'd0, '0);
        t_idle();
        chk("R7", "younger first", 32'({alu_valid, alu_tag}), 32'hc);
        chk("R7", "younger vj", 32'(alu_vj), 11);
        t_issue(2'd1, 4'd6, '0, 3'd7, 16'd2, 3'd0, '0);
        chk("R7", "none ready", 32'(alu_valid), 0);
        t_bcast(3'd7, 16'h0099);
        chk("R7", "still none", 32'(alu_valid), 0);
        t_idle();
        chk("R7", "lowest of two", 32'({alu_valid, alu_tag}), 32'hb);
        chk("R7", "vj", 32'(alu_vj), 32'h99);
        t_idle();
        chk("R7", "then 5", 32'({alu_valid, alu_tag}), 32'hd);
        chk("R7", "op", 32'(alu_op), 6);
        for (int t = 3; t <= 5; t++) t_bcast(3'(t), '0);

        // R4 sweep over operand values
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] a, b;
            a = DW'(i * 37);
            b = DW'(~(i * 11));
            t_issue(2'd1, OW'(i), a, 3'd0, b, 3'd0, '0);
            t_idle();
            chk("R4", "tag", 32'({alu_valid, alu_tag}), 32'hb);
            chk("R4", "op", 32'(alu_op), 32'(i));
            chk("R4", "vj", 32'(alu_vj), 32'(a));
            chk("R4", "vk", 32'(alu_vk), 32'(b));
            t_bcast(3'd3, '0);
        end

        // R9 sweep: wrapping addresses, Vk tag ignored
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] base, off, exp;
            base = DW'(16'hfff0 + i * 3);
            off  = DW'(i * 9 + 16'h20);
            exp  = DW'(32'(base) + 32'(off));
            t_issue(2'd0, '0, base, 3'd0, '0, 3'((i % 7) + 1), off);
            t_idle();
            chk("R9", "ld tag", 32'({ld_valid, ld_tag}), 32'h9);
            chk("R9", "ld addr", 32'(ld_addr), 32'(exp));
            t_bcast(3'd1, '0);
        end
        t_idle();
        chk("R8", "final free", 32'(free_mask), 32'h7f);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule